// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a system against software that has stopped running. Software arms it and keeps it alive through a single 32-bit control word. The word has three fields: a reload count, a start/stop command and a 7-bit key. Once the stored word has its enable bit set, software can change it again only by writing a key that is the bitwise inverse of the key already stored. A runaway write loop is therefore unlikely to keep the watchdog alive or to switch it off.

The counter steps down once per slow tick, an enable pulse of roughly 760 Hz from elsewhere in the chip. The first time it runs out, the block raises a non-maskable interrupt and starts a grace period of ten ticks. If software does not service the watchdog before the grace period also runs out, the block raises a system reset request. The request stays high until the block itself is reset.

Every accepted write restarts the countdown. The reload value comes from the count field of the word that was stored *before* the write, so a new count takes effect on the following service.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the stored control word reads 0, NMI is low, the reset request is low and the counter is stopped.
- R2: While bit 8 of the stored word is 1, a write whose key (bits [15:9]) differs from the 7-bit inverse of the stored key is ignored. After such a write the stored word, NMI and the countdown are unchanged.
- R3: While bit 8 of the stored word is 0, every write is accepted regardless of its key.
- R4: An accepted write replaces the stored word with the written value. The new value reads back on the control output from the next cycle.
- R5: An accepted write reloads the counter from bits [8:0] of the previously stored word, with 0 meaning 256. The counter then runs out on the Nth following tick, and NMI is high from the cycle after that tick.
- R6: On an accepted write, bit 8 of the written value set to 1 starts the countdown and set to 0 stops it. A stopped counter ignores ticks.
- R7: On the first run-out, NMI goes high and the counter restarts with a grace count of 10 ticks.
- R8: A run-out during the grace period raises the reset request and stops the counter. The request stays high until the block's reset.
- R9: An accepted write lowers NMI and clears the grace state, so the next run-out raises NMI again rather than the reset request.
- R10: If an accepted write and a run-out tick arrive in the same cycle, the write wins: neither NMI nor the reset request rises, and the counter is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow count enable, one cycle wide |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| nmi | output | 1 | Non-maskable interrupt after the first run-out |
| sys_rst_req | output | 1 | Sticky system reset request after the grace run-out |
| ctrl_rdata | output | 32 | Currently stored control word |

## Verification
The delicate case is a service write that lands in the same cycle as the tick that would end the countdown. In that case the write must win over both stages of expiry. The bench provokes this directly in two situations. It runs the counter down to one remaining tick during the grace period, then drives a correctly keyed write together with that tick. It then checks that NMI drops, that no reset request appears and that a following tick does not expire. Random traffic then mixes writes with right and wrong keys with ticks on every other cycle on average, which repeatedly places writes next to run-outs. Each cycle is compared against a reference model written from the requirements.

// File: rtl/wdg_pkg.sv
// Package: shared types for the keyed watchdog.
// Assumes nothing beyond standard SystemVerilog.
package wdg_pkg;

    // Expiry stage: still watching, or inside the grace period after the NMI.
    typedef enum logic {
        PH_WATCH = 1'b0,
        PH_GRACE = 1'b1
    } wdg_phase_e;

endpackage

// File: rtl/wdg_key_gate.sv
// Module: wdg_key_gate
// Holds the stored control word and decides whether a write is accepted.
// The reload value is taken from the word stored before the write.
// Assumes the enable/command bit sits directly above the count low bits,
// i.e. it is the top bit of the CNT_W-wide count field, with the key above it.
module wdg_key_gate #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 9,
    parameter int KEY_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              accept,
    output logic              start_cmd,
    output logic [CNT_W-1:0]  reload_val,
    output logic [DATA_W-1:0] ctrl_q
);
    localparam int EN_BIT  = CNT_W - 1;
    localparam int KEY_LSB = CNT_W;
    localparam int KEY_MSB = CNT_W + KEY_W - 1;
    localparam logic [CNT_W-1:0] ZERO_MEANS = CNT_W'(1) << (CNT_W - 1);

    logic [KEY_W-1:0] key_old;
    logic [KEY_W-1:0] key_new;
    logic [CNT_W-1:0] old_cnt;

    // Decode the key fields and the reload count from the stored word.
    always_comb begin
        key_old    = ctrl_q[KEY_MSB:KEY_LSB];
        key_new    = wr_data[KEY_MSB:KEY_LSB];
        old_cnt    = ctrl_q[CNT_W-1:0];
        reload_val = (old_cnt == '0) ? ZERO_MEANS : old_cnt;
        start_cmd  = wr_data[EN_BIT];
        accept     = wr_en && (!ctrl_q[EN_BIT] || (key_new == ~key_old));
    end

    // Store the written word only when the write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (accept) ctrl_q <= wr_data;
    end

    assert_reject_keeps_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(ctrl_q));

    assert_accept_stores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ctrl_q == $past(wr_data)));

endmodule

// File: rtl/wdg_countdown.sv
// Module: wdg_countdown
// One-shot down counter that steps on the slow tick.
// Priority of updates: write reload, then grace reload or halt, then decrement.
// Assumes every loaded value is at least 1, so a running counter never holds 0.
module wdg_countdown #(
    parameter int CNT_W       = 9,
    parameter int GRACE_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_run,
    input  logic             grace_load,
    input  logic             halt,
    output logic             expire,
    output logic             running
);
    localparam logic [CNT_W-1:0] GRACE_VAL = CNT_W'(GRACE_TICKS);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // A run-out is the tick that would take a running counter from 1 to 0.
    always_comb begin
        expire = running && tick && (cnt_q == ONE);
    end

    // Update the count and the run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            running <= load_run;
        end else if (grace_load) begin
            cnt_q   <= GRACE_VAL;
            running <= 1'b1;
        end else if (halt) begin
            cnt_q   <= '0;
            running <= 1'b0;
        end else if (running && tick) begin
            cnt_q   <= cnt_q - ONE;
        end
    end

    assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> ($stable(cnt_q) && !running));

    assert_grace_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grace_load && !load) |=> (running && cnt_q == GRACE_VAL));

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val) && cnt_q != '0));

endmodule

// File: rtl/wdg_stage.sv
// Module: wdg_stage
// Two-stage expiry handling: the first run-out raises NMI and asks for a grace
// reload; a run-out in the grace phase raises the sticky reset request.
// An accepted write has priority over a run-out in the same cycle.
module wdg_stage
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic expire,
    output logic grace_load,
    output logic halt,
    output logic nmi,
    output logic rst_req
);
    wdg_phase_e phase_q;

    // Route a run-out to the stage it belongs to, unless a write wins.
    always_comb begin
        grace_load = expire && !accept && (phase_q == PH_WATCH);
        halt       = expire && !accept && (phase_q == PH_GRACE);
    end

    // Track the phase and the NMI level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WATCH;
            nmi     <= 1'b0;
        end else if (accept) begin
            phase_q <= PH_WATCH;
            nmi     <= 1'b0;
        end else if (grace_load) begin
            phase_q <= PH_GRACE;
            nmi     <= 1'b1;
        end
    end

    // Latch the reset request until the block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    rst_req <= 1'b0;
        else if (halt) rst_req <= 1'b1;
    end

    assert_accept_drops_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !nmi);

    assert_request_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    assert_halt_after_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> nmi);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && expire) |=> (!nmi && $stable(rst_req)));

endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed_watchdog (top)
// Keyed two-stage watchdog: a key-protected control word, a tick-driven
// countdown, NMI on the first run-out and a sticky reset request on the second.
// Assumes tick is a single-cycle enable synchronous to clk.
module keyed_watchdog #(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 9,
    parameter int KEY_W       = 7,
    parameter int GRACE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              nmi,
    output logic              sys_rst_req,
    output logic [DATA_W-1:0] ctrl_rdata
);
    logic             accept;
    logic             start_cmd;
    logic [CNT_W-1:0] reload_val;
    logic             expire;
    logic             running;
    logic             grace_load;
    logic             halt;

    wdg_key_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .accept     (accept),
        .start_cmd  (start_cmd),
        .reload_val (reload_val),
        .ctrl_q     (ctrl_rdata)
    );

    wdg_countdown #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (accept),
        .load_val   (reload_val),
        .load_run   (start_cmd),
        .grace_load (grace_load),
        .halt       (halt),
        .expire     (expire),
        .running    (running)
    );

    wdg_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .expire     (expire),
        .grace_load (grace_load),
        .halt       (halt),
        .nmi        (nmi),
        .rst_req    (sys_rst_req)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_rdata == '0 && !nmi && !sys_rst_req && !running));

endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        nmi;
    logic        sys_rst_req;
    logic [31:0] ctrl_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [31:0] m_ctrl;
    int          m_cnt;
    bit          m_run, m_grace, m_nmi, m_rst;

    always #4 clk = ~clk;

    keyed_watchdog i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .nmi(nmi), .sys_rst_req(sys_rst_req), .ctrl_rdata(ctrl_rdata)
    );

    function automatic logic [31:0] mk(input logic [6:0] key, input logic cmd, input logic [7:0] cnt);
        return {16'h0, key, cmd, cnt};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the reference model by one clock with the given inputs.
    task automatic model_step(input bit wr, input logic [31:0] d, input bit tk);
        bit acc;
        int reload;
        acc = wr && (!m_ctrl[8] || (d[15:9] == ~m_ctrl[15:9]));
        if (acc) begin
            reload  = (m_ctrl[8:0] == 0) ? 256 : int'(m_ctrl[8:0]);
            m_cnt   = reload;
            m_run   = d[8];
            m_grace = 0;
            m_nmi   = 0;
            m_ctrl  = d;
        end else if (m_run && tk) begin
            if (m_cnt == 1) begin
                if (!m_grace) begin
                    m_nmi = 1; m_grace = 1; m_cnt = 10;
                end else begin
                    m_rst = 1; m_run = 0; m_cnt = 0;
                end
            end else begin
                m_cnt--;
            end
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic cyc(input bit wr, input logic [31:0] d, input bit tk);
        wr_en = wr; wr_data = d; tick = tk;
        @(posedge clk);
        model_step(wr, d, tk);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R4 ctrl", ctrl_rdata, m_ctrl);
        chk("R7 nmi", {31'b0, nmi}, {31'b0, m_nmi});
        chk("R8 rst_req", {31'b0, sys_rst_req}, {31'b0, m_rst});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = '0; m_cnt = 0; m_run = 0; m_grace = 0; m_nmi = 0; m_rst = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 ctrl", ctrl_rdata, 32'h0);
        chk("R1 nmi", {31'b0, nmi}, 32'h0);
        chk("R1 rst_req", {31'b0, sys_rst_req}, 32'h0);
        // R1/R6: stopped counter ignores ticks
        for (int i = 0; i < 300; i++) cyc(0, '0, 1);
        chk("R6 stopped nmi", {31'b0, nmi}, 32'h0);

        // R3: disabled word accepts any key
        cyc(1, mk(7'h2A, 0, 8'd5), 0);
        chk("R3 accept", ctrl_rdata, mk(7'h2A, 0, 8'd5));
        // R4/R6: start, reload from previous count 5
        cyc(1, mk(7'h2A, 1, 8'd3), 0);
        chk("R4 store", ctrl_rdata, mk(7'h2A, 1, 8'd3));
        for (int i = 0; i < 4; i++) cyc(0, '0, 1);
        chk("R5 before run-out", {31'b0, nmi}, 32'h0);
        cyc(0, '0, 1);
        chk("R5 nmi on 5th tick", {31'b0, nmi}, 32'h1);
        // R2: wrong key ignored
        cyc(1, mk(7'h2A, 0, 8'd0), 0);
        chk("R2 word kept", ctrl_rdata, mk(7'h2A, 1, 8'd3));
        chk("R2 nmi kept", {31'b0, nmi}, 32'h1);
        // R7: grace of 10 ticks
        for (int i = 0; i < 9; i++) cyc(0, '0, 1);
        chk("R7 grace not over", {31'b0, sys_rst_req}, 32'h0);
        cyc(0, '0, 1);
        chk("R8 reset request", {31'b0, sys_rst_req}, 32'h1);
        for (int i = 0; i < 5; i++) cyc(0, '0, 1);
        chk("R8 sticky", {31'b0, sys_rst_req}, 32'h1);

        // R9: accepted write clears NMI and grace state
        do_reset();
        cyc(1, mk(7'h00, 0, 8'd2), 0);
        cyc(1, mk(7'h11, 1, 8'd0), 0);
        cyc(0, '0, 1);
        cyc(0, '0, 1);
        chk("R9 nmi raised", {31'b0, nmi}, 32'h1);
        cyc(1, mk(7'h6E, 1, 8'd0), 0);
        chk("R9 nmi lowered", {31'b0, nmi}, 32'h0);
        for (int i = 0; i < 256; i++) cyc(0, '0, 1);
        chk("R9 nmi again", {31'b0, nmi}, 32'h1);
        chk("R9 no reset", {31'b0, sys_rst_req}, 32'h0);

        // R10: accepted write in the run-out cycle of the grace period
        for (int i = 0; i < 9; i++) cyc(0, '0, 1);
        cyc(1, mk(7'h11, 1, 8'd0), 1);
        chk("R10 no reset", {31'b0, sys_rst_req}, 32'h0);
        chk("R10 nmi low", {31'b0, nmi}, 32'h0);
        cyc(0, '0, 1);
        chk("R10 reloaded", {31'b0, nmi}, 32'h0);

        // Random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            bit wr, tk;
            logic [6:0] key;
            logic [31:0] d;
            wr  = ($urandom % 8) == 0;
            tk  = ($urandom % 2) == 0;
            key = ($urandom % 2) ? ~m_ctrl[15:9] : 7'($urandom);
            d   = mk(key, ($urandom % 4) != 0, 8'($urandom % 12));
            cyc(wr, d, tk);
            if (m_rst && ($urandom % 4) == 0) do_reset();
        end
        finish_run();
    end
endmodule